// File: doc/BRIEF.md
# Bit-Rate Tone Symbol Clock Recovery

This block recovers the bit clock of a binary phase-shift keyed stream. Its input is complex baseband samples that have already passed the matched filter and a fractional resampler, so each bit spans a whole number of samples. The block multiplies each sample by the complex conjugate of the sample half a bit earlier and keeps the real part. This creates a spectral line at the bit rate, and the line does not depend on the carrier phase. A two-pole resonator tuned to the bit rate cleans up that line. A second-order phase-locked loop then aligns a numerically controlled oscillator to the upward zero crossings of the resonator output.

Each upward zero crossing of the resonator output samples the oscillator phase, read as a signed value, and that sample is the timing error. A proportional term and a saturating integral term, both scaled by power-of-two shifts, subtract from the nominal phase step. The oscillator emits a one-cycle strobe each time its phase wraps. A lock flag reports when the timing error has stayed small for a programmed number of crossings. The data rate is chosen at run time through the half-bit delay, the nominal phase step and the resonator coefficient.

Top module: `symclk_recover`

## Requirements
- R1: During reset and on the first cycle after it, `nco_phase`, `phase_err`, `sym_strobe` and `locked` are all zero.
- R2: A cycle with `in_valid` low changes no state. The oscillator phase holds, no strobe is produced and the lock flag keeps its value.
- R3: The phase accumulator is 32 bits wide and advances once per accepted sample. Three clock edges after a sample is taken it has moved by `nom_step` minus the integrator minus any proportional kick. With an all-zero input it therefore moves by exactly `nom_step` per sample.
- R4: `sym_strobe` is high for exactly one cycle whenever an update moves the phase from the upper half of its range (bit 31 set) to the lower half (bit 31 clear).
- R5: The timing tone is `in_i[n]*in_i[n-D] + in_q[n]*in_q[n-D]`, arithmetically shifted right by `PROD_SHIFT`, where D is `half_dly` (0 is treated as 1, values above `MAX_DLY` as `MAX_DLY`). The tone therefore does not depend on a constant carrier rotation.
- R6: The resonator computes y[n] = u[n] - u[n-2] + (c*y[n-1] >>> 14) - y[n-2] + (y[n-2] >>> `bpf_damp`). Here c is `bpf_coef`, a signed value with 14 fraction bits that equals 2cos(2π/samples-per-bit). The result saturates to 32 bits.
- R7: A timing-error event happens only when the resonator output changes from negative to non-negative between two accepted samples. At that event, `phase_err` takes the current phase read as signed. An all-zero input produces no event.
- R8: At each event the integrator adds the error arithmetically shifted right by `ki_shift` and is clamped to ±`INT_LIM`. The proportional kick, the error shifted right by `kp_shift`, applies to that sample only.
- R9: Given a resampled stream at a fractional timing offset with a nominal-step error of a few hundred ppm, the loop settles within 2500 bits. After that, |`phase_err`| stays below a quarter sample (2^32/(4·samples-per-bit)) and the strobe rate equals the bit rate within one strobe per 100 bits.
- R10: `locked` rises after `lock_edges` consecutive events with |error| < `lock_thresh` and falls at the first event that fails this test.
- R11: Two data rates (8 and 12 samples per bit) are handled with one build, selected by the run-time ports alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies one input sample |
| in_i | input | IN_W | In-phase sample, signed |
| in_q | input | IN_W | Quadrature sample, signed |
| half_dly | input | DLY_W | Half-bit delay D in samples |
| bpf_coef | input | COEF_W | Resonator coefficient 2cos(w0), 14 fraction bits, signed |
| bpf_damp | input | 4 | Resonator damping shift |
| nom_step | input | 32 | Nominal phase step per sample |
| kp_shift | input | 5 | Proportional gain shift |
| ki_shift | input | 5 | Integral gain shift |
| lock_thresh | input | 32 | Error magnitude limit for lock |
| lock_edges | input | CNT_W | Consecutive good events needed for lock |
| sym_strobe | output | 1 | One-cycle pulse at each phase wrap |
| nco_phase | output | 32 | Oscillator phase accumulator |
| phase_err | output | 32 | Last sampled timing error, signed |
| locked | output | 1 | Lock indication |

## Verification
The hardest state to reach from the ports is integrator saturation. While the loop tracks, the integrator stays far below its clamp. The bench therefore sets the nominal step for six samples per bit while feeding an eight-sample-per-bit stream, so the loop can never pull in, and it sets the integral shift to zero so that a single large error drives the integrator to its limit. The bench then measures the per-sample phase increment and checks that its deviation from the nominal step reaches the clamp and never exceeds it by more than the one-count proportional kick. Rotation invariance gets its own stress: the stream is driven with I equal to Q. A sign error in the conjugate would cancel the tone completely, and the loop would then never lock.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int PHASE_W = 32;
    localparam int ACC_W   = PHASE_W + 2;

    function automatic logic signed [ACC_W-1:0] clamp_sym(
        input logic signed [ACC_W-1:0] v,
        input logic signed [ACC_W-1:0] lim
    );
        if (v > lim) begin
            return lim;
        end else if (v < -lim) begin
            return -lim;
        end
        return v;
    endfunction

endpackage

// File: rtl/scr_tone.sv
module scr_tone #(
    parameter int IN_W       = 12,
    parameter int MAX_DLY    = 32,
    parameter int DLY_W      = 6,
    parameter int PROD_SHIFT = 6,
    parameter int TONE_W     = 2 * IN_W + 1 - PROD_SHIFT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_i,
    input  logic signed [IN_W-1:0]   in_q,
    input  logic [DLY_W-1:0]         half_dly,
    output logic signed [TONE_W-1:0] tone,
    output logic                     tone_valid
);
    localparam int SMP_W  = 2 * IN_W;
    localparam int PROD_W = 2 * IN_W + 1;
    localparam int IDX_W  = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;

    typedef struct packed {
        logic [MAX_DLY-1:0][SMP_W-1:0] line;
        logic signed [TONE_W-1:0]      tone;
        logic                          vld;
    } tone_st_t;

    tone_st_t st_d, st_q;

    logic [IDX_W-1:0]         tap_idx;
    logic [SMP_W-1:0]         tap;
    logic signed [IN_W-1:0]   old_i, old_q;
    logic signed [SMP_W-1:0]  p_i, p_q;
    logic signed [PROD_W-1:0] re_sum;

    always_comb begin
        if (half_dly == '0) begin
            tap_idx = '0;
        end else if (half_dly > DLY_W'(MAX_DLY)) begin
            tap_idx = IDX_W'(MAX_DLY - 1);
        end else begin
            tap_idx = IDX_W'(half_dly - DLY_W'(1));
        end
        tap    = st_q.line[tap_idx];
        old_i  = tap[SMP_W-1:IN_W];
        old_q  = tap[IN_W-1:0];
        p_i    = in_i * old_i;
        p_q    = in_q * old_q;
        re_sum = PROD_W'(p_i) + PROD_W'(p_q);

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.line = {st_q.line[MAX_DLY-2:0], {in_i, in_q}};
            st_d.tone = TONE_W'(re_sum >>> PROD_SHIFT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tone       = st_q.tone;
    assign tone_valid = st_q.vld;

    // R2
    tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(tone) && !tone_valid));

endmodule

// File: rtl/scr_bpf.sv
module scr_bpf #(
    parameter int TONE_W    = 19,
    parameter int Y_W       = 32,
    parameter int COEF_W    = 18,
    parameter int COEF_FRAC = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [TONE_W-1:0] u,
    input  logic signed [COEF_W-1:0] coef,
    input  logic [3:0]               damp,
    output logic signed [Y_W-1:0]    y,
    output logic                     y_valid
);
    localparam int SUM_W = Y_W + 2;
    localparam int MUL_W = Y_W + COEF_W;
    localparam logic signed [SUM_W-1:0] Y_HI = SUM_W'({1'b0, {(Y_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] Y_LO = -Y_HI - SUM_W'(1);

    typedef struct packed {
        logic signed [TONE_W-1:0] u1;
        logic signed [TONE_W-1:0] u2;
        logic signed [Y_W-1:0]    y1;
        logic signed [Y_W-1:0]    y2;
        logic                     vld;
    } bpf_st_t;

    bpf_st_t st_d, st_q;

    logic signed [MUL_W-1:0] cy;
    logic signed [SUM_W-1:0] acc;
    logic signed [Y_W-1:0]   y_new;

    always_comb begin
        cy  = coef * st_q.y1;
        acc = SUM_W'(u) - SUM_W'(st_q.u2) + SUM_W'(cy >>> COEF_FRAC)
            - SUM_W'(st_q.y2) + SUM_W'(st_q.y2 >>> damp);
        if (acc > Y_HI) begin
            y_new = Y_W'(Y_HI);
        end else if (acc < Y_LO) begin
            y_new = Y_W'(Y_LO);
        end else begin
            y_new = Y_W'(acc);
        end

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.u1 = u;
            st_d.u2 = st_q.u1;
            st_d.y1 = y_new;
            st_d.y2 = st_q.y1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y       = st_q.y1;
    assign y_valid = st_q.vld;

    // R6
    bpf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y) && !y_valid));

endmodule

// File: rtl/scr_loop.sv
module scr_loop
    import scr_pkg::*;
#(
    parameter int Y_W     = 32,
    parameter int CNT_W   = 8,
    parameter int INT_LIM = 1 << 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [Y_W-1:0]     y,
    input  logic [PHASE_W-1:0]        nom_step,
    input  logic [4:0]                kp_shift,
    input  logic [4:0]                ki_shift,
    input  logic [PHASE_W-1:0]        lock_thresh,
    input  logic [CNT_W-1:0]          lock_edges,
    output logic                      strobe,
    output logic [PHASE_W-1:0]        phase,
    output logic signed [PHASE_W-1:0] phase_err,
    output logic                      locked
);
    localparam logic signed [ACC_W-1:0] LIM = ACC_W'(INT_LIM);

    typedef struct packed {
        logic signed [Y_W-1:0]     y_prev;
        logic [PHASE_W-1:0]        phase;
        logic signed [ACC_W-1:0]   integ;
        logic signed [PHASE_W-1:0] err;
        logic [CNT_W-1:0]          cnt;
        logic                      locked;
        logic                      strobe;
    } loop_st_t;

    loop_st_t st_d, st_q;

    logic                    rise, good;
    logic signed [ACC_W-1:0] e_w, mag, prop, step, thr_w, err_mag;
    logic [CNT_W-1:0]        next_cnt;

    always_comb begin
        thr_w    = ACC_W'(lock_thresh);
        rise     = st_q.y_prev[Y_W-1] & ~y[Y_W-1];
        e_w      = ACC_W'(signed'(st_q.phase));
        mag      = e_w[ACC_W-1] ? -e_w : e_w;
        good     = mag < thr_w;
        err_mag  = st_q.err[PHASE_W-1] ? -ACC_W'(st_q.err) : ACC_W'(st_q.err);
        next_cnt = (st_q.cnt < lock_edges) ? st_q.cnt + CNT_W'(1) : st_q.cnt;
        prop     = '0;
        step     = '0;

        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (in_valid) begin
            st_d.y_prev = y;
            if (rise) begin
                st_d.err   = signed'(st_q.phase);
                st_d.integ = clamp_sym(st_q.integ + (e_w >>> ki_shift), LIM);
                prop       = e_w >>> kp_shift;
                if (good) begin
                    st_d.cnt    = next_cnt;
                    st_d.locked = (next_cnt >= lock_edges);
                end else begin
                    st_d.cnt    = '0;
                    st_d.locked = 1'b0;
                end
            end
            step        = ACC_W'(nom_step) - st_d.integ - prop;
            st_d.phase  = st_q.phase + step[PHASE_W-1:0];
            st_d.strobe = st_q.phase[PHASE_W-1] & ~st_d.phase[PHASE_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe    = st_q.strobe;
    assign phase     = st_q.phase;
    assign phase_err = st_q.err;
    assign locked    = st_q.locked;

    // R8
    integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.integ <= LIM) && (st_q.integ >= -LIM));

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.phase) && !st_q.strobe && $stable(st_q.locked)));

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);

    // R10
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> ($past(in_valid) && (err_mag < thr_w)));

endmodule

// File: rtl/symclk_recover.sv
module symclk_recover #(
    parameter int IN_W       = 12,
    parameter int MAX_DLY    = 32,
    parameter int DLY_W      = $clog2(MAX_DLY + 1),
    parameter int PROD_SHIFT = 6,
    parameter int Y_W        = 32,
    parameter int COEF_W     = 18,
    parameter int COEF_FRAC  = 14,
    parameter int CNT_W      = 8,
    parameter int INT_LIM    = 1 << 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_i,
    input  logic signed [IN_W-1:0]   in_q,
    input  logic [DLY_W-1:0]         half_dly,
    input  logic signed [COEF_W-1:0] bpf_coef,
    input  logic [3:0]               bpf_damp,
    input  logic [31:0]              nom_step,
    input  logic [4:0]               kp_shift,
    input  logic [4:0]               ki_shift,
    input  logic [31:0]              lock_thresh,
    input  logic [CNT_W-1:0]         lock_edges,
    output logic                     sym_strobe,
    output logic [31:0]              nco_phase,
    output logic signed [31:0]       phase_err,
    output logic                     locked
);
    localparam int TONE_W = 2 * IN_W + 1 - PROD_SHIFT;

    logic signed [TONE_W-1:0] tone;
    logic                     tone_valid;
    logic signed [Y_W-1:0]    bp_y;
    logic                     bp_valid;

    scr_tone #(
        .IN_W(IN_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W),
        .PROD_SHIFT(PROD_SHIFT), .TONE_W(TONE_W)
    ) u_tone (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .half_dly(half_dly),
        .tone(tone), .tone_valid(tone_valid)
    );

    scr_bpf #(
        .TONE_W(TONE_W), .Y_W(Y_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
    ) u_bpf (
        .clk(clk), .rst_n(rst_n), .in_valid(tone_valid), .u(tone),
        .coef(bpf_coef), .damp(bpf_damp), .y(bp_y), .y_valid(bp_valid)
    );

    scr_loop #(
        .Y_W(Y_W), .CNT_W(CNT_W), .INT_LIM(INT_LIM)
    ) u_loop (
        .clk(clk), .rst_n(rst_n), .in_valid(bp_valid), .y(bp_y),
        .nom_step(nom_step), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .lock_thresh(lock_thresh), .lock_edges(lock_edges),
        .strobe(sym_strobe), .phase(nco_phase), .phase_err(phase_err),
        .locked(locked)
    );

endmodule

// File: tb/symclk_recover_test.sv
module symclk_recover_test;

    localparam int CLK_PERIOD = 10;
    localparam int SAT_LIM    = 1 << 24;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic [5:0]         half_dly = 6'd4;
    logic signed [17:0] bpf_coef = 18'sd23170;
    logic [3:0]         bpf_damp = 4'd4;
    logic [31:0]        nom_step = 32'd536870912;
    logic [4:0]         kp_shift = 5'd4;
    logic [4:0]         ki_shift = 5'd12;
    logic [31:0]        lock_thresh = 32'd0;
    logic [7:0]         lock_edges = 8'd16;
    logic               sym_strobe;
    logic [31:0]        nco_phase;
    logic signed [31:0] phase_err;
    logic               locked;

    int checks = 0;
    int errors = 0;
    int strobe_total = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    symclk_recover #(.INT_LIM(SAT_LIM)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .half_dly(half_dly), .bpf_coef(bpf_coef), .bpf_damp(bpf_damp),
        .nom_step(nom_step), .kp_shift(kp_shift), .ki_shift(ki_shift),
        .lock_thresh(lock_thresh), .lock_edges(lock_edges),
        .sym_strobe(sym_strobe), .nco_phase(nco_phase), .phase_err(phase_err),
        .locked(locked)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input bit v, input int i, input int q);
        @(posedge clk);
        #1;
        in_valid = v;
        in_i     = 12'(i);
        in_q     = 12'(q);
        @(negedge clk);
        if (sym_strobe) strobe_total++;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int tri_wave(input real t, input int sps);
        real p, v;
        p = t / (2.0 * sps);
        p = p - $floor(p);
        v = (p < 0.5) ? (p - 0.25) : (0.75 - p);
        return $rtoi(6000.0 * v);
    endfunction

    // R1: reset values seen during reset and right after release
    task automatic test_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(nco_phase == 0, "R1", "phase in reset", nco_phase, 0);
        check(sym_strobe == 0, "R1", "strobe in reset", sym_strobe, 0);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(phase_err == 0, "R1", "phase_err after reset", phase_err, 0);
        check(locked == 0, "R1", "locked after reset", locked, 0);
    endtask

    // R3 R4 R7 R2: free run on an all-zero input, then idle cycles
    task automatic test_free_run();
        int s0;
        longint exp_ph;
        logic [31:0] held;
        nom_step = 32'd536870912;
        do_reset();
        s0 = strobe_total;
        for (int n = 0; n < 37; n++) push(1'b1, 0, 0);
        repeat (4) push(1'b0, 0, 0);
        exp_ph = (37 * 64'd536870912) % 64'h1_0000_0000;
        check(nco_phase == exp_ph[31:0], "R3", "free-run phase", nco_phase, exp_ph);
        check(strobe_total - s0 == 4, "R4", "strobe count over 37 samples", strobe_total - s0, 4);
        check(phase_err == 0, "R7", "no timing event on zero input", phase_err, 0);
        check(locked == 0, "R7", "no lock on zero input", locked, 0);
        held = nco_phase;
        s0 = strobe_total;
        repeat (20) push(1'b0, 5, -7);
        check(nco_phase == held, "R2", "phase held while invalid", nco_phase, held);
        check(strobe_total - s0 == 0, "R2", "no strobe while invalid", strobe_total - s0, 0);
    endtask

    // R5 R6 R9 R10 R11: closed-loop convergence, then forced loss of lock
    task automatic test_lock(input int sps, input int dly, input int coef,
                             input real frac, input real ppm, input string tag);
        int nsamp, win, s0, v;
        longint pe, max_pe, thr;
        real nom_r;
        nsamp = 2500 * sps;
        win   = 100 * sps;
        nom_r = 4294967296.0 / sps * (1.0 + ppm * 1.0e-6);
        nom_step    = 32'($rtoi(nom_r));
        half_dly    = 6'(dly);
        bpf_coef    = 18'(coef);
        bpf_damp    = 4'd4;
        kp_shift    = 5'd4;
        ki_shift    = 5'd12;
        thr         = 64'h1_0000_0000 / (4 * sps);
        lock_thresh = 32'(thr);
        lock_edges  = 8'd16;
        do_reset();
        max_pe = 0;
        s0 = 0;
        for (int n = 0; n < nsamp; n++) begin
            v = tri_wave(n + frac, sps);
            push(1'b1, v, v);
            if (n == nsamp - win) s0 = strobe_total;
            if (n >= nsamp - win) begin
                pe = phase_err;
                if (pe < 0) pe = -pe;
                if (pe > max_pe) max_pe = pe;
            end
        end
        $display("%s: max |err| %0d, strobes %0d", tag, max_pe, strobe_total - s0);
        check(max_pe < thr, "R9", "settled timing error below quarter sample", max_pe, thr);
        check((strobe_total - s0 >= 99) && (strobe_total - s0 <= 101), "R9 R11",
              "strobes per 100 bits", strobe_total - s0, 100);
        check(locked == 1, "R5 R6 R10", "locked after settling (I equal to Q)", locked, 1);
        lock_thresh = 32'd0;
        for (int n = nsamp; n < nsamp + 6 * sps; n++) begin
            v = tri_wave(n + frac, sps);
            push(1'b1, v, v);
        end
        check(locked == 0, "R10", "lock drops when threshold is zero", locked, 0);
    endtask

    // R8: integrator clamp reached and never exceeded
    task automatic test_saturation();
        logic [31:0] prev, incr;
        longint dev, max_dev;
        int v;
        nom_step    = 32'd715827882;
        half_dly    = 6'd4;
        bpf_coef    = 18'sd23170;
        kp_shift    = 5'd31;
        ki_shift    = 5'd0;
        lock_thresh = 32'd0;
        do_reset();
        max_dev = 0;
        prev = nco_phase;
        for (int n = 0; n < 4000; n++) begin
            v = tri_wave(n, 8);
            push(1'b1, v, v);
            incr = nco_phase - prev;
            prev = nco_phase;
            if (n > 20) begin
                dev = longint'(signed'(nom_step - incr));
                if (dev < 0) dev = -dev;
                if (dev > max_dev) max_dev = dev;
            end
        end
        check(max_dev <= SAT_LIM + 1, "R8", "step deviation bounded by clamp", max_dev, SAT_LIM);
        check(max_dev >= SAT_LIM, "R8", "integrator reaches clamp", max_dev, SAT_LIM);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_free_run();
        test_lock(8, 4, 23170, 0.37, 200.0, "rate 8");
        test_lock(12, 6, 28378, 0.80, -300.0, "rate 12");
        test_saturation();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule